// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs the digital side of a 12-bit successive-approximation converter. After a start request it closes a sample switch for a programmable number of conversion-clock periods, opens it, waits two further periods for the held charge to settle, and then resolves the 12 bits one period at a time, MSB first. It does this by presenting a trial code to an external DAC and reading back a single comparator bit. The conversion clock is a prescaled copy of the system clock, or an alternate slow clock. Both are used as enables inside the system clock domain.

A finished conversion loads a 16-bit result register, left- or right-justified, and sets a sticky completion flag. A start bit (`go`) shows when a sequence is live, and software can clear it to abort. In continuous mode the block waits for a handshake from downstream post-processing before it restarts. It halts if a stop-on-threshold option is set and the threshold flag is high. In double-sample mode two samples form a pair, and the block reports the second minus the first.

Top module: `sar_seq_ctrl`

## Requirements
- R1: A conversion-clock period lasts 2*(clk_div_sel+1) system clocks when alt_clk_sel is 0. When alt_clk_sel is 1, a period runs from one rising edge of alt_clk to the next. The divider phase restarts whenever an acquisition begins.
- R2: After an accepted start, sample_sw is high for max(acq_count,1) conversion-clock periods. It then stays low for two settling periods before the first bit decision.
- R3: Each of the 12 bit periods decides one bit, from bit 11 down to bit 0. The comparator is captured in the middle of the period, and the trial bit is kept when cmp_in is 1 and cleared when it is 0. With cmp_in = (input >= dac_code), the final code equals the input.
- R4: One system clock after the last bit decision, result is loaded, done_flag is set and go is cleared (non-continuous, single sample). Start to done takes (max(acq_count,1)+14)*2*(clk_div_sel+1)+1 system clocks.
- R5: done_flag stays set until a done_clr pulse; it is never cleared by hardware.
- R6: A go_set or trig that arrives while go is 1 is ignored. The running conversion keeps its timing and no extra conversion follows.
- R7: With cont_en=1, go stays high after a conversion and the next one starts only after a post_done pulse. If stop_on_thr and thr_flag are both 1 at that pulse, go clears and no conversion follows.
- R8: With dbl_en=1 and cont_en=1, one start captures both samples, go stays high between them, and diff_out = second - first (13-bit two's complement).
- R9: With dbl_en=1 and cont_en=0, go clears after the first sample and a second start is needed. diff_out = second - first after it.
- R10: With fmt_right=0 the result is {code,4'b0000}; with fmt_right=1 it is {4'b0000,code}.
- R11: A go_clr pulse aborts the sequence at the next conversion-clock period end. No result is loaded, done_flag is not set, and sample_sw is low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| clk_div_sel | input | 6 | Prescaler select, divide by 2*(sel+1) |
| alt_clk_sel | input | 1 | Use alternate conversion clock |
| alt_clk | input | 1 | Alternate conversion clock level |
| acq_count | input | 13 | Acquisition length in conversion-clock periods |
| go_set | input | 1 | Software start pulse |
| trig | input | 1 | Hardware trigger pulse |
| go_clr | input | 1 | Software abort pulse |
| cont_en | input | 1 | Continuous mode |
| dbl_en | input | 1 | Double-sample mode |
| fmt_right | input | 1 | Right-justify result |
| stop_on_thr | input | 1 | Stop continuous run on threshold flag |
| thr_flag | input | 1 | Threshold flag from post-processing |
| post_done | input | 1 | Post-processing complete pulse |
| done_clr | input | 1 | Clear completion flag |
| cmp_in | input | 1 | Comparator output, 1 = input above trial |
| go | output | 1 | Sequence active |
| sample_sw | output | 1 | Sample switch closed |
| dac_code | output | 12 | Trial code to DAC |
| result | output | 16 | Justified conversion result |
| diff_out | output | 13 | Second minus first sample |
| done_flag | output | 1 | Sticky completion flag |

## Verification
Each result falls due a fixed number of system clocks after the start edge: (max(acq_count,1)+14) conversion periods of 2*(clk_div_sel+1) clocks plus one load clock. The bench counts falling edges from the start pulse to the rise of done_flag and compares that count with the formula, so both the value and the cycle are checked. The continuous, double-sample and abort cases wait on done_flag with a bounded loop. Absence is checked by a quiet window of many conversion periods after the stimulus. All outputs are sampled on the falling clock edge.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ACQ    = 3'd1,
        ST_SETTLE = 3'd2,
        ST_CONV   = 3'd3,
        ST_LOAD   = 3'd4,
        ST_WAITP  = 3'd5
    } seq_state_e;
endpackage

// File: rtl/sar_clk_tick.sv
module sar_clk_tick #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             alt_sel,
    input  logic             alt_clk,
    input  logic             restart,
    output logic             tick_mid,
    output logic             tick_end
);
    localparam int CNT_W = DIV_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             alt_q;
    } tick_t;

    tick_t q, d;
    logic [CNT_W-1:0] last_cnt;
    logic             div_mid, div_end, alt_rise, alt_fall;

    always_comb begin
        last_cnt = {div_sel, 1'b1};
        div_mid  = (q.cnt == {1'b0, div_sel});
        div_end  = (q.cnt == last_cnt);
        alt_rise = alt_clk && !q.alt_q;
        alt_fall = !alt_clk && q.alt_q;
        tick_mid = alt_sel ? alt_fall : div_mid;
        tick_end = alt_sel ? alt_rise : div_end;

        d       = q;
        d.alt_q = alt_clk;
        if (restart || div_end) d.cnt = '0;
        else                    d.cnt = q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    a_r1_mid_end_apart: assert property (@(posedge clk) disable iff (!rst_n)
        tick_end |-> !tick_mid);
    a_r1_end_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick_end |=> (!tick_end || alt_sel != $past(alt_sel) || div_sel != $past(div_sel)));
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             active,
    input  logic             tick_mid,
    input  logic             tick_end,
    input  logic             cmp_in,
    output logic [RES_W-1:0] code,
    output logic             last
);
    localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

    typedef struct packed {
        logic [RES_W-1:0] trial;
        logic [RES_W-1:0] mask;
        logic             cmp;
    } sar_t;

    sar_t q, d;
    logic [RES_W-1:0] kept, next_mask;

    always_comb begin
        d         = q;
        kept      = q.cmp ? q.trial : (q.trial & ~q.mask);
        next_mask = q.mask >> 1;
        if (init) begin
            d.trial = TOP_BIT;
            d.mask  = TOP_BIT;
            d.cmp   = 1'b0;
        end else if (active) begin
            if (tick_mid) d.cmp = cmp_in;
            if (tick_end) begin
                d.trial = kept | next_mask;
                d.mask  = next_mask;
            end
        end
        code = q.trial;
        last = q.mask[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    a_r3_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q.mask));
    a_r3_msb_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !init && tick_end && !q.cmp && q.mask[RES_W-1]) |=> !code[RES_W-1]);
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int RES_W    = 12,
    parameter int OUT_W    = 16,
    parameter int ACQ_W    = 13,
    parameter int DIV_W    = 6,
    parameter int SETTLE_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] clk_div_sel,
    input  logic             alt_clk_sel,
    input  logic             alt_clk,
    input  logic [ACQ_W-1:0] acq_count,
    input  logic             go_set,
    input  logic             trig,
    input  logic             go_clr,
    input  logic             cont_en,
    input  logic             dbl_en,
    input  logic             fmt_right,
    input  logic             stop_on_thr,
    input  logic             thr_flag,
    input  logic             post_done,
    input  logic             done_clr,
    input  logic             cmp_in,
    output logic             go,
    output logic             sample_sw,
    output logic [RES_W-1:0] dac_code,
    output logic [OUT_W-1:0] result,
    output logic [RES_W:0]   diff_out,
    output logic             done_flag
);
    localparam int PAD = OUT_W - RES_W;

    typedef struct packed {
        seq_state_e       st;
        logic             go;
        logic             sw;
        logic [ACQ_W-1:0] cnt;
        logic             second;
        logic [RES_W-1:0] first;
        logic [OUT_W-1:0] res;
        logic [RES_W:0]   diff;
        logic             done;
    } seq_t;

    seq_t q, d;
    logic             tick_mid, tick_end, enter_acq, sar_init, sar_last;
    logic [RES_W-1:0] sar_code;

    sar_clk_tick #(.DIV_W(DIV_W)) tick_i (
        .clk(clk), .rst_n(rst_n), .div_sel(clk_div_sel), .alt_sel(alt_clk_sel),
        .alt_clk(alt_clk), .restart(enter_acq), .tick_mid(tick_mid), .tick_end(tick_end)
    );

    sar_bit_engine #(.RES_W(RES_W)) sar_i (
        .clk(clk), .rst_n(rst_n), .init(sar_init), .active(q.st == ST_CONV),
        .tick_mid(tick_mid), .tick_end(tick_end), .cmp_in(cmp_in),
        .code(sar_code), .last(sar_last)
    );

    always_comb begin
        d         = q;
        enter_acq = 1'b0;
        sar_init  = 1'b0;
        if (done_clr) d.done = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (!q.go && (go_set || trig)) begin
                    d.go      = 1'b1;
                    d.st      = ST_ACQ;
                    d.sw      = 1'b1;
                    d.cnt     = acq_count;
                    enter_acq = 1'b1;
                end
            end
            ST_ACQ, ST_SETTLE, ST_CONV: begin
                if (tick_end) begin
                    if (!q.go) begin
                        d.st     = ST_IDLE;
                        d.sw     = 1'b0;
                        d.second = 1'b0;
                    end else if (q.st == ST_ACQ) begin
                        if (q.cnt <= ACQ_W'(1)) begin
                            d.st  = ST_SETTLE;
                            d.sw  = 1'b0;
                            d.cnt = ACQ_W'(SETTLE_N - 1);
                        end else begin
                            d.cnt = q.cnt - ACQ_W'(1);
                        end
                    end else if (q.st == ST_SETTLE) begin
                        if (q.cnt == '0) begin
                            d.st     = ST_CONV;
                            sar_init = 1'b1;
                        end else begin
                            d.cnt = q.cnt - ACQ_W'(1);
                        end
                    end else if (sar_last) begin
                        d.st = ST_LOAD;
                    end
                end
            end
            ST_LOAD: begin
                if (!q.go) begin
                    d.st     = ST_IDLE;
                    d.second = 1'b0;
                end else begin
                    d.res  = fmt_right ? {{PAD{1'b0}}, sar_code} : {sar_code, {PAD{1'b0}}};
                    d.done = 1'b1;
                    if (dbl_en && !q.second) begin
                        d.first  = sar_code;
                        d.second = 1'b1;
                        if (cont_en) begin
                            d.st      = ST_ACQ;
                            d.sw      = 1'b1;
                            d.cnt     = acq_count;
                            enter_acq = 1'b1;
                        end else begin
                            d.go = 1'b0;
                            d.st = ST_IDLE;
                        end
                    end else begin
                        if (dbl_en) d.diff = {1'b0, sar_code} - {1'b0, q.first};
                        d.second = 1'b0;
                        if (cont_en) begin
                            d.st = ST_WAITP;
                        end else begin
                            d.go = 1'b0;
                            d.st = ST_IDLE;
                        end
                    end
                end
            end
            ST_WAITP: begin
                if (!q.go) begin
                    d.st = ST_IDLE;
                end else if (post_done) begin
                    if (stop_on_thr && thr_flag) begin
                        d.go = 1'b0;
                        d.st = ST_IDLE;
                    end else begin
                        d.st      = ST_ACQ;
                        d.sw      = 1'b1;
                        d.cnt     = acq_count;
                        enter_acq = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (go_clr) d.go = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign go        = q.go;
    assign sample_sw = q.sw;
    assign dac_code  = sar_code;
    assign result    = q.res;
    assign diff_out  = q.diff;
    assign done_flag = q.done;

    a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && !done_clr) |=> q.done);
    a_r4_done_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> $past(q.st == ST_LOAD));
    a_r2_switch_open: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SETTLE || q.st == ST_CONV) |-> !sample_sw);
    a_r10_left_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LOAD && q.go && !fmt_right) |=> (result[PAD-1:0] == '0));
    a_r10_right_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LOAD && q.go && fmt_right) |=> (result[OUT_W-1:RES_W] == '0));
    a_r11_abort_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.go && (q.st == ST_ACQ || q.st == ST_SETTLE || q.st == ST_CONV)) |=> !$rose(q.done));
endmodule

// File: tb/sar_seq_ctrl_tb.sv
module sar_seq_ctrl_tb_top;
    localparam time CLK_P = 20ns;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [5:0]  clk_div_sel = '0;
    logic        alt_clk_sel = 1'b0, alt_clk = 1'b0, alt_run = 1'b0;
    logic [12:0] acq_count = '0;
    logic        go_set = 0, trig = 0, go_clr = 0, cont_en = 0, dbl_en = 0, fmt_right = 0;
    logic        stop_on_thr = 0, thr_flag = 0, post_done = 0, done_clr = 0;
    logic        cmp_in, go, sample_sw, done_flag;
    logic [11:0] dac_code, vin = '0;
    logic [15:0] result;
    logic [12:0] diff_out;

    int n_vec = 0, n_bad = 0;

    always #(CLK_P/2) clk = ~clk;
    always #(5*CLK_P) if (alt_run) alt_clk = ~alt_clk;

    assign cmp_in = (vin >= dac_code);

    sar_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .clk_div_sel(clk_div_sel), .alt_clk_sel(alt_clk_sel),
        .alt_clk(alt_clk), .acq_count(acq_count), .go_set(go_set), .trig(trig),
        .go_clr(go_clr), .cont_en(cont_en), .dbl_en(dbl_en), .fmt_right(fmt_right),
        .stop_on_thr(stop_on_thr), .thr_flag(thr_flag), .post_done(post_done),
        .done_clr(done_clr), .cmp_in(cmp_in), .go(go), .sample_sw(sample_sw),
        .dac_code(dac_code), .result(result), .diff_out(diff_out), .done_flag(done_flag)
    );

    // vector: {vin, fmt_right, clk_div_sel, acq_count}
    typedef struct packed {
        logic [11:0] v;
        logic        f;
        logic [5:0]  s;
        logic [12:0] a;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{12'hABC, 1'b1, 6'd0,  13'd0},
        '{12'hABC, 1'b0, 6'd0,  13'd1},
        '{12'h000, 1'b1, 6'd1,  13'd3},
        '{12'hFFF, 1'b1, 6'd2,  13'd5},
        '{12'h800, 1'b0, 6'd63, 13'd2},
        '{12'h7FF, 1'b1, 6'd3,  13'd100},
        '{12'h555, 1'b0, 6'd0,  13'd8191}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit && !done_flag; i++) @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int exp_cycles(input logic [5:0] s, input logic [12:0] a);
        int n = (a == 0) ? 1 : int'(a);
        return (n + 14) * 2 * (int'(s) + 1) + 1;
    endfunction

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int cyc;
        int sw_cnt;
        logic [15:0] held;
        logic [12:0] exp_diff;

        idle(3);
        chk("R4 reset go", {31'b0, go}, 0);
        chk("R4 reset done", {31'b0, done_flag}, 0);
        chk("R4 reset result", {16'b0, result}, 0);
        chk("R8 reset diff", {19'b0, diff_out}, 0);
        chk("R2 reset switch", {31'b0, sample_sw}, 0);
        rst_n = 1'b1;
        idle(2);

        // R1 R3 R4 R10: table walk, value and completion cycle
        foreach (VECS[k]) begin
            vin = VECS[k].v; fmt_right = VECS[k].f;
            clk_div_sel = VECS[k].s; acq_count = VECS[k].a;
            pulse(done_clr);
            pulse(go_set);
            cyc = 0;
            while (!done_flag && cyc < 30000) begin @(negedge clk); cyc++; end
            chk("R3 R10 result", {16'b0, result},
                {16'b0, (VECS[k].f ? {4'b0, VECS[k].v} : {VECS[k].v, 4'b0})});
            chk("R1 R4 cycles", cyc, exp_cycles(VECS[k].s, VECS[k].a));
            chk("R4 go cleared", {31'b0, go}, 0);
        end

        // R5: flag holds without clear
        idle(50);
        chk("R5 done sticky", {31'b0, done_flag}, 1);

        // R2: switch closed for acq periods
        clk_div_sel = 6'd1; acq_count = 13'd3; vin = 12'h123; fmt_right = 1;
        pulse(done_clr);
        pulse(go_set);
        sw_cnt = 0;
        while (!done_flag) begin if (sample_sw) sw_cnt++; @(negedge clk); end
        chk("R2 acquisition length", sw_cnt, 3 * 4);

        // R6: starts while busy are ignored
        clk_div_sel = 6'd0; acq_count = 13'd3; vin = 12'h321;
        pulse(done_clr);
        pulse(go_set);
        cyc = 0;
        while (!done_flag) begin
            @(negedge clk); cyc++;
            if (cyc == 5)  trig = 1'b1;
            if (cyc == 6)  trig = 1'b0;
            if (cyc == 20) go_set = 1'b1;
            if (cyc == 21) go_set = 1'b0;
        end
        chk("R6 timing kept", cyc, exp_cycles(6'd0, 13'd3));
        pulse(done_clr);
        idle(100);
        chk("R6 no extra conversion", {31'b0, done_flag}, 0);

        // R7: continuous mode gated by post_done, stop on threshold
        cont_en = 1; vin = 12'h456; acq_count = 13'd2;
        pulse(go_set);
        wait_done(200);
        chk("R7 go held", {31'b0, go}, 1);
        pulse(done_clr);
        idle(100);
        chk("R7 waits for post_done", {31'b0, done_flag}, 0);
        vin = 12'h654;
        pulse(post_done);
        wait_done(200);
        chk("R7 restarted result", {16'b0, result}, 32'h0654);
        pulse(done_clr);
        stop_on_thr = 1; thr_flag = 1;
        pulse(post_done);
        chk("R7 stop on threshold", {31'b0, go}, 0);
        idle(100);
        chk("R7 no conversion after stop", {31'b0, done_flag}, 0);
        stop_on_thr = 0; thr_flag = 0;

        // R8: double sample, continuous
        dbl_en = 1; acq_count = 13'd4; vin = 12'd1000;
        pulse(go_set);
        wait_done(200);
        vin = 12'd1300;
        chk("R8 go held between samples", {31'b0, go}, 1);
        pulse(done_clr);
        wait_done(200);
        exp_diff = 13'd300;
        chk("R8 pair difference", {19'b0, diff_out}, {19'b0, exp_diff});
        chk("R8 second sample", {16'b0, result}, 32'd1300);
        pulse(go_clr);
        idle(2);

        // R9: double sample, single shot
        cont_en = 0;
        pulse(done_clr);
        pulse(go_set);
        wait_done(200);
        chk("R9 go clears after first", {31'b0, go}, 0);
        vin = 12'd900;
        pulse(done_clr);
        pulse(go_set);
        wait_done(200);
        exp_diff = 13'd900 - 13'd1300;
        chk("R9 pair difference", {19'b0, diff_out}, {19'b0, exp_diff});
        dbl_en = 0;

        // R11: abort mid conversion
        held = result;
        vin = 12'hEEE; acq_count = 13'd2;
        pulse(done_clr);
        pulse(go_set);
        idle(14);
        pulse(go_clr);
        idle(60);
        chk("R11 no done", {31'b0, done_flag}, 0);
        chk("R11 result kept", {16'b0, result}, {16'b0, held});
        chk("R11 switch open", {31'b0, sample_sw}, 0);

        // R1: alternate conversion clock
        alt_run = 1; alt_clk_sel = 1; vin = 12'h9A5;
        pulse(go_set);
        wait_done(5000);
        chk("R1 alternate clock result", {16'b0, result}, 32'h09A5);
        alt_run = 0;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule